// File: doc/BRIEF.md
# Acquisition Stream Packetizer

The packetizer turns the 32-bit sample stream of one acquisition channel into a valid/ready output stream. A one-cycle start pulse begins an acquisition. At that pulse the block captures the mode, the header enable, the buffer length, the 64-bit timestamp and the trigger count. In triggered mode it sends a fixed number of 32-bit words. When the header is enabled, the first four of those words are a header: two timestamp halves, the trigger count and the buffer length. The header words count toward the buffer length. In continuous mode it forwards samples until a fault stops it, and the header and length settings are ignored.

Output beats are cut into 4096-byte frames. The final beat of each frame carries a last marker, and so does the closing beat of a triggered buffer. A 26-bit counter reports the number of complete frames. Status pins mirror the input valid, the downstream ready and the enabled state, and they show a sticky frame-done flag and a sticky error flag.

The stream does not tolerate back-pressure. The block never holds a beat back waiting for ready. If downstream ready is low while the block is enabled, that is a fault. If input valid is low while the block is enabled outside the header, that is also a fault. A fault halts the acquisition and sets the error flag, which holds until the next start pulse.

Top module: `acq_pktz`

## Requirements
- R1: A start pulse captures the configuration inputs, clears the error flag, the frame counter, the frame-done flag and the position counters, and enables the block from the next cycle. During the cycle in which start is high, no beat is offered and no fault is detected.
- R2: In triggered mode (mode_trig_i = 1) exactly buf_words_i beats are sent, after which stat_enabled_o falls. A length of zero sends nothing and leaves the block disabled.
- R3: In triggered mode with hdr_en_i = 1, beats 0..3 of the buffer are, in order: ts_i[31:0], ts_i[63:32], trig_cnt_i, and the buffer length zero-extended. These beats count toward the length. A length below 4 truncates the header.
- R4: In continuous mode (mode_trig_i = 0), hdr_en_i and buf_words_i have no effect. Only samples are sent, with no end until a fault or a new start.
- R5: Outside the header, out_valid_o follows in_valid_i and out_data_o equals in_data_i while the block is enabled.
- R6: out_last_o is high on every 1024th accepted beat counted from the start, and on the final beat of a triggered buffer.
- R7: frame_cnt_o (26 bits) increments once per completed 1024-beat frame. stat_frame_done_o is set by the first completed frame. Neither changes otherwise until the next start.
- R8: If out_ready_i is low while the block is enabled, the offered beat is not counted. stat_err_o rises on the next cycle and stat_enabled_o falls, and no further beat is offered.
- R9: If in_valid_i is low while the block is enabled and not in the header, stat_err_o rises on the next cycle and the stream halts. A gap in valid during the header is harmless.
- R10: stat_in_valid_o mirrors in_valid_i, stat_ready_o mirrors out_ready_i, and stat_ovf_o is always 0.
- R11: When a start pulse coincides with a fault condition, the start takes precedence: the next cycle shows no error and the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle acquisition start pulse |
| mode_trig_i | input | 1 | 1 = triggered buffer, 0 = continuous |
| hdr_en_i | input | 1 | Prepend a four-word header (triggered only) |
| buf_words_i | input | SIZE_W | Buffer length in 32-bit words, header included |
| ts_i | input | 64 | Timestamp placed in the header |
| trig_cnt_i | input | 32 | Trigger count placed in the header |
| in_data_i | input | 32 | Sample word |
| in_valid_i | input | 1 | Sample valid |
| out_data_o | output | 32 | Output beat data |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_last_o | output | 1 | Frame or buffer end marker |
| stat_frame_done_o | output | 1 | Sticky: at least one full frame sent |
| stat_ready_o | output | 1 | Mirror of downstream ready |
| stat_ovf_o | output | 1 | Overflow flag, constant 0 |
| stat_err_o | output | 1 | Sticky acquisition error |
| stat_in_valid_o | output | 1 | Mirror of input valid |
| stat_enabled_o | output | 1 | Acquisition in progress |
| frame_cnt_o | output | CNT_W | Completed frames since the last start |

## Verification
Two functions can fall in the same cycle. The first is a restart pulse and a fault condition. The bench raises start while an acquisition is running and, in the same cycle, drops both input valid and downstream ready. The next cycle must show the error flag clear and the block enabled, and the following beats must restart from frame position zero.

The second is a frame boundary that is also the final beat of a triggered buffer. A 32-word buffer with 16-word test frames provokes it. The scoreboard expects a single last marker on that beat and a frame count of two.

// File: rtl/acq_pktz_pkg.sv
package acq_pktz_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_BEATS = 4;

  typedef enum logic [1:0] {
    HW_TS_LO = 2'd0,
    HW_TS_HI = 2'd1,
    HW_TRIG  = 2'd2,
    HW_SIZE  = 2'd3
  } hdr_word_e;
endpackage

// File: rtl/acq_pktz_hdr.sv
module acq_pktz_hdr
  import acq_pktz_pkg::*;
#(
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [63:0]       ts_i,
  input  logic [31:0]       trig_cnt_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        sel_i,
  output logic [WORD_W-1:0] word_o
);
  logic [63:0]       ts_q;
  logic [31:0]       tc_q;
  logic [SIZE_W-1:0] size_q;
  logic [WORD_W-1:0] size_word;
  hdr_word_e         sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q   <= '0;
      tc_q   <= '0;
      size_q <= '0;
    end else if (load_i) begin
      ts_q   <= ts_i;
      tc_q   <= trig_cnt_i;
      size_q <= size_i;
    end
  end

  generate
    if (SIZE_W == WORD_W) begin : g_full
      assign size_word = size_q;
    end else begin : g_ext
      assign size_word = {{(WORD_W-SIZE_W){1'b0}}, size_q};
    end
  endgenerate

  assign sel = hdr_word_e'(sel_i);

  always_comb begin
    unique case (sel)
      HW_TS_LO: word_o = ts_q[31:0];
      HW_TS_HI: word_o = ts_q[63:32];
      HW_TRIG:  word_o = tc_q;
      default:  word_o = size_word;
    endcase
  end
endmodule

// File: rtl/acq_pktz_seq.sv
module acq_pktz_seq
  import acq_pktz_pkg::*;
#(
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_trig_i,
  input  logic              hdr_en_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              in_valid_i,
  input  logic              out_ready_i,
  output logic              active_o,
  output logic              hdr_phase_o,
  output logic [1:0]        hdr_sel_o,
  output logic              offer_o,
  output logic              beat_o,
  output logic              last_buf_o,
  output logic              err_o
);
  logic              active;
  logic              trig_q;
  logic              hdr_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] wcnt;
  logic              err;
  logic              fault;
  logic              live;

  assign live        = active && !start_i;
  assign hdr_phase_o = active && trig_q && hdr_q && (wcnt < SIZE_W'(HDR_BEATS));
  assign hdr_sel_o   = wcnt[1:0];
  assign offer_o     = live && (hdr_phase_o || in_valid_i);
  assign beat_o      = offer_o && out_ready_i;
  assign last_buf_o  = trig_q && (wcnt == size_q - SIZE_W'(1));
  assign fault       = live && (!out_ready_i || (!hdr_phase_o && !in_valid_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      trig_q <= 1'b0;
      hdr_q  <= 1'b0;
      size_q <= '0;
      wcnt   <= '0;
      err    <= 1'b0;
    end else if (start_i) begin
      active <= !(mode_trig_i && (size_i == '0));
      trig_q <= mode_trig_i;
      hdr_q  <= hdr_en_i;
      size_q <= size_i;
      wcnt   <= '0;
      err    <= 1'b0;
    end else if (fault) begin
      active <= 1'b0;
      err    <= 1'b1;
    end else if (beat_o && trig_q) begin
      wcnt <= wcnt + SIZE_W'(1);
      if (last_buf_o) active <= 1'b0;
    end
  end

  assign active_o = active;
  assign err_o    = err;
endmodule

// File: rtl/acq_pktz_frame.sv
module acq_pktz_frame #(
  parameter int FRAME_WORDS = 1024,
  parameter int CNT_W       = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic             last_buf_i,
  output logic             last_o,
  output logic [CNT_W-1:0] frame_cnt_o,
  output logic             done_o
);
  localparam int POS_W = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;

  logic [POS_W-1:0] fpos;
  logic             frame_end;

  assign frame_end = (fpos == POS_W'(FRAME_WORDS - 1));
  assign last_o    = frame_end || last_buf_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      fpos        <= '0;
      frame_cnt_o <= '0;
      done_o      <= 1'b0;
    end else if (beat_i) begin
      if (frame_end) begin
        fpos        <= '0;
        frame_cnt_o <= frame_cnt_o + CNT_W'(1);
        done_o      <= 1'b1;
      end else begin
        fpos <= fpos + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/acq_pktz.sv
module acq_pktz
  import acq_pktz_pkg::*;
#(
  parameter int SIZE_W      = 32,
  parameter int FRAME_BYTES = 4096,
  parameter int CNT_W       = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_trig_i,
  input  logic              hdr_en_i,
  input  logic [SIZE_W-1:0] buf_words_i,
  input  logic [63:0]       ts_i,
  input  logic [31:0]       trig_cnt_i,
  input  logic [31:0]       in_data_i,
  input  logic              in_valid_i,
  output logic [31:0]       out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_last_o,
  output logic              stat_frame_done_o,
  output logic              stat_ready_o,
  output logic              stat_ovf_o,
  output logic              stat_err_o,
  output logic              stat_in_valid_o,
  output logic              stat_enabled_o,
  output logic [CNT_W-1:0]  frame_cnt_o
);
  localparam int FRAME_WORDS = FRAME_BYTES / (WORD_W / 8);

  logic              active;
  logic              hdr_phase;
  logic [1:0]        hdr_sel;
  logic              offer;
  logic              beat;
  logic              last_buf;
  logic              err;
  logic              frame_last;
  logic [WORD_W-1:0] hdr_word;

  acq_pktz_seq #(.SIZE_W(SIZE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_trig_i (mode_trig_i),
    .hdr_en_i    (hdr_en_i),
    .size_i      (buf_words_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .active_o    (active),
    .hdr_phase_o (hdr_phase),
    .hdr_sel_o   (hdr_sel),
    .offer_o     (offer),
    .beat_o      (beat),
    .last_buf_o  (last_buf),
    .err_o       (err)
  );

  acq_pktz_hdr #(.SIZE_W(SIZE_W)) u_hdr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (start_i),
    .ts_i       (ts_i),
    .trig_cnt_i (trig_cnt_i),
    .size_i     (buf_words_i),
    .sel_i      (hdr_sel),
    .word_o     (hdr_word)
  );

  acq_pktz_frame #(.FRAME_WORDS(FRAME_WORDS), .CNT_W(CNT_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (start_i),
    .beat_i      (beat),
    .last_buf_i  (last_buf),
    .last_o      (frame_last),
    .frame_cnt_o (frame_cnt_o),
    .done_o      (stat_frame_done_o)
  );

  assign out_data_o      = hdr_phase ? hdr_word : in_data_i;
  assign out_valid_o     = offer;
  assign out_last_o      = offer && frame_last;
  assign stat_ready_o    = out_ready_i;
  assign stat_ovf_o      = 1'b0;
  assign stat_err_o      = err;
  assign stat_in_valid_o = in_valid_i;
  assign stat_enabled_o  = active;
endmodule

// File: rtl/acq_pktz_chk.sv
module acq_pktz_chk #(
  parameter int CNT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             out_ready_i,
  input logic             out_valid_o,
  input logic             out_last_o,
  input logic             stat_err_o,
  input logic             stat_enabled_o,
  input logic [CNT_W-1:0] frame_cnt_o,
  input logic             hdr_phase
);
  p_start_clears_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !stat_err_o);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_enabled_o |-> !out_valid_o);

  p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(out_valid_o && out_ready_i && out_last_o)) |=> $stable(frame_cnt_o));

  p_ready_drop_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> stat_err_o);

  p_halted_on_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_err_o |-> (!out_valid_o && !stat_enabled_o));

  p_valid_drop_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_enabled_o && !start_i && !hdr_phase && !in_valid_i) |=> stat_err_o);

  p_start_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && stat_enabled_o && !out_ready_i) |=> !stat_err_o);
endmodule

bind acq_pktz acq_pktz_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .in_valid_i     (in_valid_i),
  .out_ready_i    (out_ready_i),
  .out_valid_o    (out_valid_o),
  .out_last_o     (out_last_o),
  .stat_err_o     (stat_err_o),
  .stat_enabled_o (stat_enabled_o),
  .frame_cnt_o    (frame_cnt_o),
  .hdr_phase      (hdr_phase)
);

// File: tb/sim_acq_pktz.sv
`timescale 1ns/1ps
module sim_acq_pktz;
  localparam int FB = 64;
  localparam int FW = FB / 4;
  localparam int CW = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_trig_i = 1'b0;
  logic        hdr_en_i = 1'b0;
  logic [31:0] buf_words_i = '0;
  logic [63:0] ts_i = 64'h1111_2222_3333_4444;
  logic [31:0] trig_cnt_i = 32'h0000_0055;
  logic [31:0] in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        out_ready_i = 1'b1;
  logic [31:0] out_data_o;
  logic        out_valid_o;
  logic        out_last_o;
  logic        stat_frame_done_o, stat_ready_o, stat_ovf_o, stat_err_o;
  logic        stat_in_valid_o, stat_enabled_o;
  logic [CW-1:0] frame_cnt_o;

  int checks = 0;
  int fails  = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  acq_pktz #(.SIZE_W(32), .FRAME_BYTES(FB), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_trig_i(mode_trig_i),
    .hdr_en_i(hdr_en_i), .buf_words_i(buf_words_i), .ts_i(ts_i),
    .trig_cnt_i(trig_cnt_i), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_last_o(out_last_o), .stat_frame_done_o(stat_frame_done_o),
    .stat_ready_o(stat_ready_o), .stat_ovf_o(stat_ovf_o), .stat_err_o(stat_err_o),
    .stat_in_valid_o(stat_in_valid_o), .stat_enabled_o(stat_enabled_o),
    .frame_cnt_o(frame_cnt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected beat per accepted output beat
  always @(negedge clk) begin
    if (rst_n && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected beat", {31'd0, out_last_o, out_data_o}, 64'h1_FFFF_FFFF_FFFF);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {31'd0, out_last_o, out_data_o}, {31'd0, e});
      end
    end
  end

  function automatic logic [31:0] hdr_word(input int i, input logic [31:0] sz);
    case (i)
      0: return ts_i[31:0];
      1: return ts_i[63:32];
      2: return trig_cnt_i;
      default: return sz;
    endcase
  endfunction

  // Driver: starts an acquisition, drives samples and pushes expected beats
  task automatic run(input bit trig, input bit hdr, input int size, input int ncyc,
                     input int vdrop, input int rdrop, input logic [31:0] seed);
    int  idx = 0;
    bit  stopped;
    bit  dropped = 0;
    bit  hp;
    bit  lst;
    stopped = trig && (size == 0);
    @(posedge clk); #1;
    start_i = 1'b1; mode_trig_i = trig; hdr_en_i = hdr; buf_words_i = size;
    in_valid_i = 1'b1; out_ready_i = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      start_i = 1'b0;
      in_data_i = seed + c;
      in_valid_i = (c != vdrop);
      out_ready_i = (c != rdrop);
      if (!stopped) begin
        hp = trig && hdr && (idx < 4);
        if (c == rdrop || (!hp && c == vdrop)) begin
          stopped = 1; dropped = 1;
        end else begin
          lst = ((idx + 1) % FW == 0) || (trig && idx + 1 == size);
          exp_q.push_back({lst, hp ? hdr_word(idx, size) : seed + c});
          tag_q.push_back(hp ? "R3 header beat" : (lst ? "R6 last beat" : "R5 data beat"));
          idx++;
          if (trig && idx == size) stopped = 1;
        end
      end
    end
    @(posedge clk); #1;
    in_valid_i = 1'b0; out_ready_i = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R2 queue drained", exp_q.size(), 0);
    chk("R7 frame count", frame_cnt_o, idx / FW);
    chk("R7 frame done", stat_frame_done_o, idx >= FW);
    chk(dropped ? "R8/R9 error flag" : "R2 error flag", stat_err_o, dropped || !trig);
    chk("R2 enabled after run", stat_enabled_o, 0);
  endtask

  task automatic final_report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    final_report();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #2;
    // R1 reset state
    chk("R1 reset valid", out_valid_o, 0);
    chk("R1 reset err", stat_err_o, 0);
    chk("R1 reset enabled", stat_enabled_o, 0);
    chk("R1 reset frames", frame_cnt_o, 0);
    // R10 mirrors in idle
    @(posedge clk); #1;
    in_valid_i = 1'b1; out_ready_i = 1'b0;
    #1;
    chk("R10 valid mirror", stat_in_valid_o, 1);
    chk("R10 ready mirror", stat_ready_o, 0);
    chk("R10 overflow zero", stat_ovf_o, 0);
    chk("R2 idle quiet", out_valid_o, 0);
    out_ready_i = 1'b1; in_valid_i = 1'b0;

    // R3, R6: triggered with header, partial last frame
    run(1, 1, 40, 48, -1, -1, 32'h1000_0000);
    // R6, R7: buffer end coincides with a frame end
    run(1, 0, 32, 40, -1, -1, 32'h2000_0000);
    // R3: truncated header
    run(1, 1, 3, 8, -1, -1, 32'h3000_0000);
    // R2: zero length
    run(1, 1, 0, 6, -1, -1, 32'h4000_0000);
    // R9: valid gap inside header is harmless
    run(1, 1, 10, 14, 1, -1, 32'h5000_0000);
    // R4, R9: continuous with header bit set, stopped by valid drop
    run(0, 1, 5, 50, 45, -1, 32'h6000_0000);
    // R8: continuous stopped by ready drop
    run(0, 0, 0, 30, -1, 20, 32'h7000_0000);
    // R1: error cleared by start after an error run
    @(posedge clk); #1; start_i = 1'b1; mode_trig_i = 1'b1; buf_words_i = 2;
    hdr_en_i = 1'b0; in_valid_i = 1'b0;
    @(posedge clk); #1; start_i = 1'b0;
    #1;
    chk("R1 start clears error", stat_err_o, 0);
    chk("R1 enabled after start", stat_enabled_o, 1);
    out_ready_i = 1'b1;
    @(posedge clk); #1;
    repeat (2) @(posedge clk);
    #1;

    // R11: start coinciding with a fault condition
    @(posedge clk); #1;
    start_i = 1'b1; mode_trig_i = 1'b0; hdr_en_i = 1'b0; in_valid_i = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk); #1;
      start_i = 1'b0; in_data_i = 32'h8000_0000 + c; in_valid_i = 1'b1;
      exp_q.push_back({1'b0, 32'h8000_0000 + c}); tag_q.push_back("R5 data beat");
    end
    @(posedge clk); #1;
    start_i = 1'b1; in_valid_i = 1'b0; out_ready_i = 1'b0;
    @(posedge clk); #1;
    start_i = 1'b0; out_ready_i = 1'b1; in_valid_i = 1'b1; in_data_i = 32'h9000_0000;
    chk("R11 start beats fault: err", stat_err_o, 0);
    chk("R11 start beats fault: enabled", stat_enabled_o, 1);
    exp_q.push_back({1'b0, 32'h9000_0000}); tag_q.push_back("R11 restarted beat");
    for (int c = 1; c < FW; c++) begin
      @(posedge clk); #1;
      in_data_i = 32'h9000_0000 + c;
      exp_q.push_back({c == FW - 1, 32'h9000_0000 + c});
      tag_q.push_back(c == FW - 1 ? "R11 frame restarted at zero" : "R5 data beat");
    end
    @(posedge clk); #1; in_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R11 queue drained", exp_q.size(), 0);
    chk("R7 one frame after restart", frame_cnt_o, 1);
    chk("R9 halted by valid drop", stat_err_o, 1);
    final_report();
  end
endmodule